// File: doc/BRIEF.md
# MDIO Management Master

This block is the station-management master for a PHY bus. It turns one register-level request into one complete management frame on an MDC/MDIO pair. Software first loads a 16-bit write-data register, then writes a command. The command holds a 2-bit operation, a PHY address and a register field. The block then derives MDC from the system clock and shifts the frame out MSB first. For reads it releases MDIO at the turnaround and captures the 16 data bits the PHY returns.

A configuration register selects the framing. Mode 0 gives the older single-frame register access. Mode 1 gives the extended two-step access: an address frame first, then a data frame to the same PHY and device. In mode 1 the register field of the command carries the device number. The configuration register also holds the preamble enable and the MDC half-period. Software polls two flags to see when a transfer has finished: a pending flag for address and write frames, and a pending flag for reads. A read-valid flag and the returned data show the outcome of the last read.

Top module: `mdio_master`

## Requirements
- R1: After reset, `wr_pending`, `rd_pending` and `rd_valid` are 0, `mdc` is 0 and `mdio_oe` is 0 (MDIO released).
- R2: While a frame runs, `mdc` is a square wave whose period is 2×`cfg_half` system clocks. While idle, `mdc` stays at 0.
- R3: A mode-0 command with op 0 sends a write frame. The frame is: 32 ones (if the preamble is enabled), start 01, wire op 01, 5-bit PHY, 5-bit register, turnaround 10, then the 16 write-data bits. All fields go MSB first, and each bit changes just after an MDC rising edge.
- R4: A mode-0 command with op 1 sends start 01 and wire op 10, then PHY and register. The master then releases MDIO for 18 bit times and samples MDIO on each MDC rising edge. The last 16 samples become `rd_data`, MSB first.
- R5: In mode 1, start is 00 and the wire op equals the command op (0 address, 1 write, 2 read with post-increment, 3 read). The register field carries the device number. Address and write frames send the write-data register as their 16 data bits. Ops 2 and 3 are read frames shaped as in R4.
- R6: A configuration write with mode 1 forces the preamble on, whatever the preamble bit says. In mode 0 with the preamble off, a frame has no preamble bits.
- R7: An accepted address or write command sets `wr_pending`, and an accepted read command sets `rd_pending`. Each flag is set on the clock after the command write and clears when the frame ends. The two flags are never set together.
- R8: `rd_valid` clears when a read is accepted. At the end of the read it is set if the PHY drove MDIO low during the second turnaround bit, and it stays 0 otherwise (no PHY response).
- R9: A command written while either pending flag is set is ignored. No second frame follows, and the running frame is unchanged.
- R10: `mdio_oe` is 0 while idle. During a read it is 0 from the first turnaround bit to the end of the frame. During an address or write frame it is 1 for the whole frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the configuration register |
| cfg_c45 | input | 1 | Framing mode: 0 single-frame access, 1 extended (address then data) access |
| cfg_pre | input | 1 | Preamble enable (forced on when cfg_c45 is 1) |
| cfg_half | input | DIV_W | MDC half-period in system clocks (0 treated as 1) |
| wdat_we | input | 1 | Write strobe for the write-data register |
| wdat | input | DATA_W | Write data, or the register address for an address frame |
| cmd_we | input | 1 | Command write strobe; starts a frame when idle |
| cmd_op | input | 2 | Operation code, interpreted according to the mode |
| cmd_phy | input | PHY_W | PHY address |
| cmd_reg | input | REG_W | Register address (mode 0) or device number (mode 1) |
| wr_pending | output | 1 | Address or write frame in progress |
| rd_pending | output | 1 | Read frame in progress |
| rd_valid | output | 1 | Last read was answered by a PHY |
| rd_data | output | DATA_W | Data captured by the last read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 = master drives) |
| mdio_i | input | 1 | MDIO input value |

## Verification
A PHY model in the bench answers reads, and every driven bit is captured at the MDC rising edge and compared with a frame built from the requirements.

The frames tried are:
- mode-0 writes with and without the preamble, which separates the start and op encodings and the preamble length;
- mode-0 reads with and without a PHY acknowledge, which shows where MDIO is released and how `rd_valid` follows the second turnaround bit;
- all four mode-1 ops with the preamble bit written as 0, which proves the forced preamble and the pass-through op encoding;
- a command issued during a running frame, which must leave exactly one frame on the wire.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   // Configuration held between commands
   typedef struct packed {
      logic c45;   // 1: extended framing
      logic pre;   // preamble enable
   } mdio_cfg_t;

   localparam logic [1:0] START_C22 = 2'b01;
   localparam logic [1:0] START_C45 = 2'b00;
   localparam logic [1:0] TA_MASTER = 2'b10;

   // Wire op code sent after the start bits
   function automatic logic [1:0] wire_op(input logic c45, input logic [1:0] op);
      logic [1:0] w;
      if (c45) w = op;
      else     w = op[0] ? 2'b10 : 2'b01;
      return w;
   endfunction

   // Whether the command op is a read in the given mode
   function automatic logic op_reads(input logic c45, input logic [1:0] op);
      return c45 ? op[1] : op[0];
   endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] half,
   output logic             mdc,
   output logic             rise,
   output logic             fall
);
   timeunit 1ns; timeprecision 100ps;

   localparam logic [DIV_W-1:0] ONE = {{(DIV_W-1){1'b0}}, 1'b1};

   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] lim;
   logic             term;

   assign lim  = (half == '0) ? '0 : half - ONE;
   assign term = (cnt >= lim);
   assign rise = run & term & ~mdc;
   assign fall = run & term & mdc;

   // R2: the divider only runs while a frame is active
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else if (!run) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else if (term) begin
         cnt <= '0;
         mdc <= ~mdc;
      end else begin
         cnt <= cnt + ONE;
      end
   end
endmodule

// File: rtl/mdio_frame_fmt.sv
module mdio_frame_fmt
   import mdio_pkg::*;
#(
   parameter int PRE_LEN = 32,
   parameter int PHY_W   = 5,
   parameter int REG_W   = 5,
   parameter int DATA_W  = 16,
   localparam int HDR_W   = 4 + PHY_W + REG_W,
   localparam int CORE_W  = HDR_W + 2 + DATA_W,
   localparam int FRAME_W = PRE_LEN + CORE_W,
   localparam int IDX_W   = $clog2(FRAME_W + 1)
) (
   input  logic               c45,
   input  logic               pre,
   input  logic [1:0]         op,
   input  logic [PHY_W-1:0]   phy,
   input  logic [REG_W-1:0]   regad,
   input  logic [DATA_W-1:0]  wdat,
   output logic [FRAME_W-1:0] frame,
   output logic               is_rd,
   output logic [IDX_W-1:0]   first
);
   timeunit 1ns; timeprecision 100ps;

   logic [CORE_W-1:0] core;

   // R3/R5: start, op, addresses, turnaround, data, MSB first
   assign core  = {(c45 ? START_C45 : START_C22), wire_op(c45, op),
                   phy, regad, TA_MASTER, wdat};
   assign is_rd = op_reads(c45, op);

   // Frame is left-aligned so the shifter always sends from the top bit
   generate
      if (PRE_LEN == 0) begin : g_nopre
         assign frame = core;
         assign first = '0;
      end else begin : g_pre
         localparam logic [IDX_W-1:0] PRE_IDX = IDX_W'(PRE_LEN);
         assign frame = pre ? {{PRE_LEN{1'b1}}, core} : {core, {PRE_LEN{1'b0}}};
         assign first = pre ? '0 : PRE_IDX;
      end
   endgenerate
endmodule

// File: rtl/mdio_engine.sv
module mdio_engine #(
   parameter int PRE_LEN = 32,
   parameter int PHY_W   = 5,
   parameter int REG_W   = 5,
   parameter int DATA_W  = 16,
   localparam int HDR_W   = 4 + PHY_W + REG_W,
   localparam int FRAME_W = PRE_LEN + HDR_W + 2 + DATA_W,
   localparam int IDX_W   = $clog2(FRAME_W + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [FRAME_W-1:0] frame_in,
   input  logic               rd_in,
   input  logic [IDX_W-1:0]   first_in,
   input  logic               rise,
   input  logic               fall,
   input  logic               mdio_i,
   output logic               mdio_o,
   output logic               mdio_oe,
   output logic               wr_pend,
   output logic               rd_pend,
   output logic               rd_valid,
   output logic [DATA_W-1:0]  rd_data
);
   timeunit 1ns; timeprecision 100ps;

   localparam logic [IDX_W-1:0] REL_IDX = IDX_W'(PRE_LEN + HDR_W);
   localparam logic [IDX_W-1:0] ACK_IDX = IDX_W'(PRE_LEN + HDR_W + 1);
   localparam logic [IDX_W-1:0] DAT_IDX = IDX_W'(PRE_LEN + HDR_W + 2);
   localparam logic [IDX_W-1:0] END_IDX = IDX_W'(FRAME_W);
   localparam logic [IDX_W-1:0] ONE     = {{(IDX_W-1){1'b0}}, 1'b1};

   logic [FRAME_W-1:0] frame_q;
   logic [IDX_W-1:0]   idx;
   logic               ack;
   logic [DATA_W-1:0]  rd_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_q  <= '0;
         idx      <= '0;
         ack      <= 1'b0;
         rd_sh    <= '0;
         wr_pend  <= 1'b0;
         rd_pend  <= 1'b0;
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else if (start) begin
         frame_q  <= frame_in;
         idx      <= first_in;
         wr_pend  <= ~rd_in;
         rd_pend  <= rd_in;
         rd_valid <= 1'b0;       // R8
         ack      <= 1'b0;
      end else begin
         if (rise && idx != END_IDX) begin
            frame_q <= {frame_q[FRAME_W-2:0], 1'b0};
            idx     <= idx + ONE;
            if (rd_pend && idx == ACK_IDX) ack <= ~mdio_i;
            if (rd_pend && idx >= DAT_IDX) rd_sh <= {rd_sh[DATA_W-2:0], mdio_i};
         end
         if (fall && idx == END_IDX) begin
            wr_pend <= 1'b0;
            rd_pend <= 1'b0;
            if (rd_pend) begin
               rd_valid <= ack;
               rd_data  <= rd_sh;
            end
         end
      end
   end

   // R10: release MDIO from the turnaround on for reads
   assign mdio_oe = wr_pend | (rd_pend & (idx < REL_IDX));
   assign mdio_o  = frame_q[FRAME_W-1];
endmodule

// File: rtl/mdio_master.sv
module mdio_master
   import mdio_pkg::*;
#(
   parameter int DIV_W    = 8,
   parameter int RST_HALF = 4,
   parameter int PRE_LEN  = 32,
   parameter int PHY_W    = 5,
   parameter int REG_W    = 5,
   parameter int DATA_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_c45,
   input  logic              cfg_pre,
   input  logic [DIV_W-1:0]  cfg_half,
   input  logic              wdat_we,
   input  logic [DATA_W-1:0] wdat,
   input  logic              cmd_we,
   input  logic [1:0]        cmd_op,
   input  logic [PHY_W-1:0]  cmd_phy,
   input  logic [REG_W-1:0]  cmd_reg,
   output logic              wr_pending,
   output logic              rd_pending,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i
);
   timeunit 1ns; timeprecision 100ps;

   localparam int HDR_W   = 4 + PHY_W + REG_W;
   localparam int FRAME_W = PRE_LEN + HDR_W + 2 + DATA_W;
   localparam int IDX_W   = $clog2(FRAME_W + 1);

   generate
      if (DIV_W < 2)    begin : g_bad_div  $error("DIV_W must be at least 2");   end
      if (DATA_W < 2)   begin : g_bad_data $error("DATA_W must be at least 2");  end
      if (PHY_W < 1 || REG_W < 1) begin : g_bad_adr $error("address widths must be positive"); end
      if (PRE_LEN < 0)  begin : g_bad_pre  $error("PRE_LEN must not be negative"); end
      if (RST_HALF < 1 || RST_HALF >= (1 << DIV_W)) begin : g_bad_half
         $error("RST_HALF must fit DIV_W and be non-zero");
      end
   endgenerate

   mdio_cfg_t          cfg_q;
   logic [DIV_W-1:0]   half_q;
   logic [DATA_W-1:0]  wdat_q;
   logic               busy, start, rise, fall, is_rd;
   logic [FRAME_W-1:0] frame;
   logic [IDX_W-1:0]   first;

   // R6: entering extended mode forces the preamble on
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '{c45: 1'b0, pre: 1'b1};
         half_q <= DIV_W'(RST_HALF);
         wdat_q <= '0;
      end else begin
         if (cfg_we) begin
            cfg_q.c45 <= cfg_c45;
            cfg_q.pre <= cfg_pre | cfg_c45;
            half_q    <= cfg_half;
         end
         if (wdat_we) wdat_q <= wdat;
      end
   end

   assign busy  = wr_pending | rd_pending;
   assign start = cmd_we & ~busy;   // R9: commands while busy are dropped

   mdio_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
      .clk(clk), .rst_n(rst_n), .run(busy), .half(half_q),
      .mdc(mdc), .rise(rise), .fall(fall)
   );

   mdio_frame_fmt #(.PRE_LEN(PRE_LEN), .PHY_W(PHY_W), .REG_W(REG_W), .DATA_W(DATA_W)) u_fmt (
      .c45(cfg_q.c45), .pre(cfg_q.pre), .op(cmd_op), .phy(cmd_phy), .regad(cmd_reg),
      .wdat(wdat_q), .frame(frame), .is_rd(is_rd), .first(first)
   );

   mdio_engine #(.PRE_LEN(PRE_LEN), .PHY_W(PHY_W), .REG_W(REG_W), .DATA_W(DATA_W)) u_eng (
      .clk(clk), .rst_n(rst_n), .start(start), .frame_in(frame), .rd_in(is_rd),
      .first_in(first), .rise(rise), .fall(fall), .mdio_i(mdio_i),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .wr_pend(wr_pending), .rd_pend(rd_pending),
      .rd_valid(rd_valid), .rd_data(rd_data)
   );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
   input logic clk,
   input logic rst_n,
   input logic mdc,
   input logic mdio_oe,
   input logic wr_pending,
   input logic rd_pending,
   input logic rd_valid
);
   timeunit 1ns; timeprecision 100ps;

   // R7: the two pending flags never overlap
   a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_pending && rd_pending));

   // R2: MDC rests low whenever no frame is running
   a_r2_mdc_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_pending || rd_pending) |-> !mdc);

   // R2: an MDC rising edge only follows a busy cycle
   a_r2_rise_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mdc) |-> $past(wr_pending || rd_pending));

   // R10: MDIO released while idle
   a_r10_released_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_pending || rd_pending) |-> !mdio_oe);

   // R10: once a read releases MDIO it stays released
   a_r10_read_stays_released: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_pending && !mdio_oe) |=> !mdio_oe);

   // R10: address and write frames drive MDIO throughout
   a_r10_write_drives: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pending |-> mdio_oe);

   // R8: valid is clear for the whole of a read
   a_r8_valid_clear_in_read: assert property (@(posedge clk) disable iff (!rst_n)
      rd_pending |-> !rd_valid);
endmodule

bind mdio_master mdio_master_chk u_chk (
   .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_oe(mdio_oe),
   .wr_pending(wr_pending), .rd_pending(rd_pending), .rd_valid(rd_valid)
);

// File: tb/mdio_master_test.sv
module mdio_master_test;
   timeunit 1ns; timeprecision 100ps;

   localparam int H = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0, cfg_c45 = 1'b0, cfg_pre = 1'b0;
   logic [7:0]  cfg_half = 8'd0;
   logic        wdat_we = 1'b0;
   logic [15:0] wdat = 16'h0;
   logic        cmd_we = 1'b0;
   logic [1:0]  cmd_op = 2'b0;
   logic [4:0]  cmd_phy = 5'h0, cmd_reg = 5'h0;
   logic        wr_pending, rd_pending, rd_valid, mdc, mdio_o, mdio_oe;
   logic [15:0] rd_data;
   logic        mdio_i = 1'b1;

   always #2.5 clk = ~clk;

   mdio_master uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_c45(cfg_c45), .cfg_pre(cfg_pre),
      .cfg_half(cfg_half), .wdat_we(wdat_we), .wdat(wdat), .cmd_we(cmd_we), .cmd_op(cmd_op),
      .cmd_phy(cmd_phy), .cmd_reg(cmd_reg), .wr_pending(wr_pending), .rd_pending(rd_pending),
      .rd_valid(rd_valid), .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
      .mdio_i(mdio_i)
   );

   typedef struct {
      logic [63:0] bits;
      int          n;
      bit          rd;
      bit          ack;
      logic [15:0] rdata;
      string       tag;
   } exp_t;

   exp_t        sb[$];
   int          checks = 0, fails = 0, frames_done = 0;
   logic [15:0] phy_data = 16'h0;
   bit          phy_ack = 1'b1;
   bit          m_c45 = 1'b0, m_pre = 1'b1;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Monitor / PHY model, all on the falling system clock edge
   logic [63:0] cap = 64'h0;
   int          ncap = 0, rel = 0;
   logic        pm = 1'b0, po = 1'b0, poe = 1'b0, pb = 1'b0;
   longint      cyc = 0, last_rise = -1;
   bit          per_done = 1'b0;

   always @(negedge clk) begin
      exp_t e;
      cyc++;
      if (mdc && !pm) begin
         if (poe) begin
            cap = {cap[62:0], po};
            ncap++;
         end
         if (!per_done && last_rise >= 0) begin
            chk(cyc - last_rise == 2 * H, "R2", "mdc period", cyc - last_rise, 2 * H);
            per_done = 1'b1;
         end
         last_rise = cyc;
      end
      if (!mdc && pm) begin
         if (mdio_oe || !rd_pending) begin
            rel = 0;
            mdio_i = 1'b1;
         end else begin
            rel++;
            if (rel == 1)       mdio_i = 1'b1;
            else if (rel == 2)  mdio_i = !phy_ack;
            else if (rel <= 18) mdio_i = phy_data[18 - rel];
         end
      end
      if (pb && !(wr_pending || rd_pending)) begin
         frames_done++;
         if (sb.size() == 0) begin
            chk(1'b0, "R9", "unexpected frame", 64'(ncap), 0);
         end else begin
            e = sb.pop_front();
            chk(ncap == e.n, e.tag, "driven bit count", 64'(ncap), 64'(e.n));
            chk(cap == e.bits, e.tag, "driven bits", cap, e.bits);
            if (e.rd) begin
               chk(rd_valid == e.ack, e.tag, "rd_valid", 64'(rd_valid), 64'(e.ack));
               if (e.ack) chk(rd_data == e.rdata, e.tag, "rd_data", 64'(rd_data), 64'(e.rdata));
            end
         end
         ncap = 0;
         cap  = 64'h0;
      end
      pm  = mdc;
      po  = mdio_o;
      poe = mdio_oe;
      pb  = wr_pending || rd_pending;
   end

   task automatic set_cfg(input bit c45, input bit pre);
      @(posedge clk); #1;
      cfg_we = 1'b1; cfg_c45 = c45; cfg_pre = pre; cfg_half = 8'(H);
      @(posedge clk); #1;
      cfg_we = 1'b0;
      m_c45 = c45;
      m_pre = pre | c45;   // R6
   endtask

   // Driver: builds the expected frame from the requirements and pushes it
   task automatic issue(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] rg,
                        input logic [15:0] data, input logic [15:0] rdat, input bit ack,
                        input string tag);
      exp_t        e;
      logic [13:0] hdr;
      logic [1:0]  wop;
      bit          rd;
      rd  = m_c45 ? op[1] : op[0];
      wop = m_c45 ? op : (op[0] ? 2'b10 : 2'b01);
      hdr = {(m_c45 ? 2'b00 : 2'b01), wop, phy, rg};
      if (rd) begin
         e.bits = 64'(hdr);
         e.n    = 14;
      end else begin
         e.bits = 64'({hdr, 2'b10, data});
         e.n    = 32;
      end
      if (m_pre) begin
         e.bits = e.bits | (64'h0000_0000_FFFF_FFFF << e.n);
         e.n    = e.n + 32;
      end
      e.rd = rd; e.ack = ack; e.rdata = rdat; e.tag = tag;
      phy_data = rdat;
      phy_ack  = ack;
      @(posedge clk); #1;
      wdat_we = 1'b1; wdat = data;
      @(posedge clk); #1;
      wdat_we = 1'b0;
      sb.push_back(e);
      cmd_we = 1'b1; cmd_op = op; cmd_phy = phy; cmd_reg = rg;
      @(posedge clk); #1;
      cmd_we = 1'b0;
      chk(wr_pending == !rd && rd_pending == rd, "R7", "pending flags after command",
          64'({wr_pending, rd_pending}), 64'({!rd, rd}));
      if (rd) chk(!rd_valid, "R8", "rd_valid cleared at read start", 64'(rd_valid), 0);
   endtask

   task automatic wait_idle();
      do @(negedge clk); while (wr_pending || rd_pending);
      repeat (4) @(negedge clk);
   endtask

   initial begin
      #(5.0 * 150000);
      checks++;
      fails++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int n0;
      repeat (3) @(negedge clk);
      chk(!wr_pending && !rd_pending && !rd_valid, "R1", "flags in reset",
          64'({wr_pending, rd_pending, rd_valid}), 0);
      chk(!mdc && !mdio_oe, "R1", "mdc/oe in reset", 64'({mdc, mdio_oe}), 0);
      @(posedge clk); #1 rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!mdc && !mdio_oe && !wr_pending && !rd_pending, "R1", "idle after reset",
          64'({mdc, mdio_oe, wr_pending, rd_pending}), 0);

      // Mode 0, preamble on
      set_cfg(1'b0, 1'b1);
      issue(2'd0, 5'h13, 5'h0A, 16'hA5C3, 16'h0, 1'b1, "R3 R10");
      wait_idle();
      chk(!mdc && !mdio_oe, "R2", "mdc low and MDIO released when idle",
          64'({mdc, mdio_oe}), 0);
      issue(2'd1, 5'h01, 5'h02, 16'h0, 16'h3C5A, 1'b1, "R4 R10");
      wait_idle();
      issue(2'd1, 5'h1E, 5'h11, 16'h0, 16'hFFFF, 1'b0, "R8");
      wait_idle();

      // Mode 0, preamble off
      set_cfg(1'b0, 1'b0);
      issue(2'd0, 5'h0C, 5'h1F, 16'h5A0F, 16'h0, 1'b1, "R6 R3");
      wait_idle();
      issue(2'd1, 5'h07, 5'h03, 16'h0, 16'h8001, 1'b1, "R6 R4");
      wait_idle();

      // Mode 1, preamble bit written 0 but forced on
      set_cfg(1'b1, 1'b0);
      issue(2'd0, 5'h02, 5'h03, 16'h1234, 16'h0, 1'b1, "R5 R6");
      wait_idle();
      issue(2'd1, 5'h02, 5'h03, 16'hBEEF, 16'h0, 1'b1, "R5");
      wait_idle();
      issue(2'd3, 5'h02, 5'h03, 16'h0, 16'h0F0F, 1'b1, "R5 R10");
      wait_idle();
      issue(2'd2, 5'h15, 5'h1E, 16'h0, 16'hF00D, 1'b1, "R5");
      wait_idle();
      issue(2'd3, 5'h15, 5'h01, 16'h0, 16'h0, 1'b0, "R8 R5");
      wait_idle();

      // R9: a command during a running frame is dropped
      n0 = frames_done;
      issue(2'd1, 5'h09, 5'h04, 16'hC0DE, 16'h0, 1'b1, "R9 R5");
      repeat (20) @(posedge clk);
      #1;
      cmd_we = 1'b1; cmd_op = 2'd3; cmd_phy = 5'h1F; cmd_reg = 5'h1F;
      @(posedge clk); #1;
      cmd_we = 1'b0;
      @(negedge clk);
      chk(wr_pending && !rd_pending, "R9", "flags unchanged by dropped command",
          64'({wr_pending, rd_pending}), 64'(2'b10));
      wait_idle();
      repeat (300) @(negedge clk);
      chk(!wr_pending && !rd_pending, "R9", "no second frame started",
          64'({wr_pending, rd_pending}), 0);
      chk(frames_done == n0 + 1, "R9", "frame count", 64'(frames_done), 64'(n0 + 1));
      chk(sb.size() == 0, "R9", "scoreboard drained", 64'(sb.size()), 0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule